// File: doc/BRIEF.md
# Memory Multiply-Accumulate String Engine

This block is a sequential engine that walks two arrays in memory in step and forms the sum of the element-wise products. It accepts two start addresses, an element count and a 96-bit running sum, supplied as three 32-bit words. On each iteration it fetches one element from the first array and then one from the second through a read-only memory port. It multiplies the two elements as signed numbers and adds the product into the 96-bit sum.

When the count reaches zero, the engine narrows the top word of the sum to a sign-extended 16-bit value. It then raises a sign flag and an overflow flag that describe that word. It returns the final pointers, the count and the sum, with a one-cycle done pulse.

A host loads the working values with a start pulse and waits for done. The memory side uses a request/acknowledge handshake. Each handshake returns one element in the low bits of the read data.

Top module: `mem_mac_engine`

## Requirements
- R1: After reset, busy, done, mem_req, flag_s and flag_o are 0. A start pulse seen while idle latches the pointers, count, sum and size and sets busy. mem_req is never high while busy is low.
- R2: Each iteration issues exactly one read at the first pointer and then one read at the second pointer. mem_req and mem_addr hold steady until mem_ack. The element size is coded on size_sel as 0 for 8 bits, 1 for 16 bits, and 2 or 3 for 32 bits.
- R3: Each pointer advances by the element size in bytes (1, 2 or 4) after each of its reads. The final pointer is therefore the start pointer plus count times size.
- R4: An element is taken from the low 8, 16 or 32 bits of mem_rdata and sign-extended. Any read-data bits above the element are ignored.
- R5: The two elements are multiplied as signed values into a 64-bit product. The product is sign-extended to 96 bits and added modulo 2^96 into {acc_hi, acc_mid, acc_lo}, with carries passing between the words.
- R6: The count drops by one per element pair and is 0 at completion.
- R7: At completion, bits 31:16 of acc_hi become copies of its bit 15.
- R8: At completion, flag_s equals bit 31 of the final acc_hi. flag_o is 1 exactly when the final acc_hi is neither 0x00000000 nor 0xFFFFFFFF.
- R9: A start with a count of 0 makes no memory request and leaves acc_lo and acc_mid unchanged. It still applies R7 and R8. done is high in the second cycle after the start edge.
- R10: A start pulse, or a change on the load inputs, while busy has no effect on the result.
- R11: done is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin an operation when idle |
| size_sel | input | 2 | Element size code |
| in_ptr_a | input | AW | First array start address |
| in_ptr_b | input | AW | Second array start address |
| in_count | input | CW | Element pair count |
| in_acc_lo | input | 32 | Sum, bits 31:0 |
| in_acc_mid | input | 32 | Sum, bits 63:32 |
| in_acc_hi | input | 32 | Sum, bits 95:64 |
| busy | output | 1 | Operation in progress |
| done | output | 1 | Completion pulse |
| out_ptr_a | output | AW | First pointer |
| out_ptr_b | output | AW | Second pointer |
| out_count | output | CW | Remaining count |
| out_acc_lo | output | 32 | Sum, bits 31:0 |
| out_acc_mid | output | 32 | Sum, bits 63:32 |
| out_acc_hi | output | 32 | Sum, bits 95:64 |
| flag_s | output | 1 | Sign of final top word |
| flag_o | output | 1 | Top word not a pure sign extension |
| mem_req | output | 1 | Read request |
| mem_addr | output | AW | Read address |
| mem_ack | input | 1 | Read acknowledge, data valid |
| mem_rdata | input | 32 | Read data, element in low bits |

## Verification
The bench fills the read data above each element with a fixed nonzero pattern. A design that failed to mask those bits, or that sign-extended from the wrong bit, would then produce wrong products.

The low and middle sum words start at all ones, so every carry must ripple into the top word. An engine that dropped the inter-word carry, or that zero-extended a negative product, would be caught there.

Zero-count starts are checked for exact done timing, for the absence of any request, and for the top-word narrowing and flag results. One run changes the load inputs and pulses start during the operation. A design that accepted a restart or read the inputs live would end with a different sum or pointers.

// File: rtl/mem_mac_engine.sv
module mem_mac_engine #(
  parameter int AW = 32,
  parameter int CW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    size_sel,
  input  logic [AW-1:0] in_ptr_a,
  input  logic [AW-1:0] in_ptr_b,
  input  logic [CW-1:0] in_count,
  input  logic [31:0]   in_acc_lo,
  input  logic [31:0]   in_acc_mid,
  input  logic [31:0]   in_acc_hi,
  output logic          busy,
  output logic          done,
  output logic [AW-1:0] out_ptr_a,
  output logic [AW-1:0] out_ptr_b,
  output logic [CW-1:0] out_count,
  output logic [31:0]   out_acc_lo,
  output logic [31:0]   out_acc_mid,
  output logic [31:0]   out_acc_hi,
  output logic          flag_s,
  output logic          flag_o,
  output logic          mem_req,
  output logic [AW-1:0] mem_addr,
  input  logic          mem_ack,
  input  logic [31:0]   mem_rdata
);
  typedef enum logic [2:0] {S_IDLE, S_RDA, S_RDB, S_MAC, S_FIN, S_DONE} state_t;

  state_t        state;
  logic [1:0]    sz;
  logic [AW-1:0] pa, pb;
  logic [CW-1:0] cnt;
  logic [95:0]   acc;
  logic [31:0]   ea, eb, elem, hi_ext;
  logic [2:0]    step;
  logic [63:0]   prod;
  logic          fs, fo;

  always_comb begin
    case (sz)
      2'd0:    elem = {{24{mem_rdata[7]}}, mem_rdata[7:0]};
      2'd1:    elem = {{16{mem_rdata[15]}}, mem_rdata[15:0]};
      default: elem = mem_rdata;
    endcase
  end

  assign step   = (sz == 2'd0) ? 3'd1 : (sz == 2'd1) ? 3'd2 : 3'd4;
  assign prod   = $signed({{32{ea[31]}}, ea}) * $signed({{32{eb[31]}}, eb});
  assign hi_ext = {{16{acc[79]}}, acc[79:64]};

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= S_IDLE;
      sz    <= 2'd0;
      pa    <= '0;
      pb    <= '0;
      cnt   <= '0;
      acc   <= '0;
      ea    <= '0;
      eb    <= '0;
      fs    <= 1'b0;
      fo    <= 1'b0;
    end else begin
      case (state)
        S_IDLE: if (start) begin
          sz    <= size_sel;
          pa    <= in_ptr_a;
          pb    <= in_ptr_b;
          cnt   <= in_count;
          acc   <= {in_acc_hi, in_acc_mid, in_acc_lo};
          state <= (in_count == '0) ? S_FIN : S_RDA;
        end
        S_RDA: if (mem_ack) begin
          ea    <= elem;
          pa    <= pa + {{(AW-3){1'b0}}, step};
          state <= S_RDB;
        end
        S_RDB: if (mem_ack) begin
          eb    <= elem;
          pb    <= pb + {{(AW-3){1'b0}}, step};
          state <= S_MAC;
        end
        S_MAC: begin
          acc   <= acc + {{32{prod[63]}}, prod};
          cnt   <= cnt - {{(CW-1){1'b0}}, 1'b1};
          state <= (cnt == {{(CW-1){1'b0}}, 1'b1}) ? S_FIN : S_RDA;
        end
        S_FIN: begin
          acc[95:64] <= hi_ext;
          fs    <= hi_ext[31];
          fo    <= (hi_ext != 32'h0) && (hi_ext != 32'hFFFF_FFFF);
          state <= S_DONE;
        end
        default: state <= S_IDLE;
      endcase
    end
  end

  assign busy        = (state != S_IDLE);
  assign done        = (state == S_DONE);
  assign mem_req     = (state == S_RDA) || (state == S_RDB);
  assign mem_addr    = (state == S_RDB) ? pb : pa;
  assign out_ptr_a   = pa;
  assign out_ptr_b   = pb;
  assign out_count   = cnt;
  assign out_acc_lo  = acc[31:0];
  assign out_acc_mid = acc[63:32];
  assign out_acc_hi  = acc[95:64];
  assign flag_s      = fs;
  assign flag_o      = fo;
endmodule

// File: rtl/mem_mac_engine_chk.sv
module mem_mac_engine_chk #(
  parameter int AW = 32,
  parameter int CW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          done,
  input logic          mem_req,
  input logic          mem_ack,
  input logic [AW-1:0] mem_addr,
  input logic [CW-1:0] out_count,
  input logic [31:0]   out_acc_hi,
  input logic          flag_s
);
  assert_idle_no_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req);

  assert_req_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)));

  assert_count_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !done) |=> (out_count == $past(out_count) || out_count == $past(out_count) - 1));

  assert_hi_extended_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (out_acc_hi[31:16] == {16{out_acc_hi[15]}}));

  assert_sign_flag_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (flag_s == out_acc_hi[31]));

  assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
endmodule

bind mem_mac_engine mem_mac_engine_chk #(.AW(AW), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .mem_req(mem_req),
  .mem_ack(mem_ack), .mem_addr(mem_addr), .out_count(out_count),
  .out_acc_hi(out_acc_hi), .flag_s(flag_s)
);

// File: tb/test_mem_mac_engine.sv
module test_mem_mac_engine;
  logic        clk = 0, rst_n = 0, start = 0;
  logic [1:0]  size_sel = 0;
  logic [31:0] in_ptr_a = 0, in_ptr_b = 0, in_count = 0;
  logic [31:0] in_acc_lo = 0, in_acc_mid = 0, in_acc_hi = 0;
  logic        busy, done, flag_s, flag_o, mem_req, mem_ack = 0;
  logic [31:0] out_ptr_a, out_ptr_b, out_count, out_acc_lo, out_acc_mid, out_acc_hi;
  logic [31:0] mem_addr, mem_rdata = 0;

  int unsigned vectors = 0, miscompares = 0, cycles = 0;
  int          lat = 0, wcnt = 0, cur_sz = 0;
  logic [31:0] addr_q[$];

  always #10 clk = ~clk;

  mem_mac_engine i_mem_mac_engine (.*);

  function automatic logic [7:0] byte_at(logic [31:0] ad);
    logic [31:0] t = ad * 32'd2654435761;
    return t[23:16] ^ ad[7:0];
  endfunction

  function automatic logic [31:0] raw_el(logic [31:0] ad, int nb);
    logic [31:0] v = 0;
    for (int i = 0; i < nb; i++) v = v | ({24'h0, byte_at(ad + i)} << (8 * i));
    return v;
  endfunction

  function automatic longint sx(logic [31:0] v, int nb);
    if (nb == 1) return longint'($signed(v[7:0]));
    if (nb == 2) return longint'($signed(v[15:0]));
    return longint'($signed(v));
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // memory responder; also checks the request order (R2, R3)
  always @(negedge clk) begin
    mem_ack <= 1'b0;
    if (mem_req && !mem_ack) begin
      if (wcnt >= lat) begin
        int nb;
        logic [31:0] mask;
        nb = (cur_sz == 0) ? 1 : (cur_sz == 1) ? 2 : 4;
        mask = (nb == 4) ? 32'hFFFF_FFFF : ((32'h1 << (8 * nb)) - 1);
        mem_ack   <= 1'b1;
        mem_rdata <= raw_el(mem_addr, nb) | (32'hA5C3_9E71 & ~mask);
        wcnt      <= 0;
        if (addr_q.size() == 0) chk("R2/R9 unexpected request", mem_addr, 32'hFFFF_FFFF);
        else chk("R2 read address order", mem_addr, addr_q.pop_front());
      end else wcnt <= wcnt + 1;
    end
  end

  task automatic run_case(int sz, logic [31:0] a, logic [31:0] b, int n,
                          logic [31:0] hi, logic [31:0] mid, logic [31:0] lo,
                          int l, bit poke);
    int nb;
    logic [95:0] acc;
    logic [31:0] hx;
    nb = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    acc = {hi, mid, lo};
    addr_q.delete();
    for (int k = 0; k < n; k++) begin
      longint p;
      logic [63:0] pv;
      addr_q.push_back(a + k * nb);
      addr_q.push_back(b + k * nb);
      p  = sx(raw_el(a + k * nb, nb), nb) * sx(raw_el(b + k * nb, nb), nb);
      pv = p;
      acc = acc + {{32{pv[63]}}, pv};
    end
    hx = {{16{acc[79]}}, acc[79:64]};
    lat = l; cur_sz = sz;
    @(negedge clk);
    size_sel = sz[1:0]; in_ptr_a = a; in_ptr_b = b; in_count = n;
    in_acc_hi = hi; in_acc_mid = mid; in_acc_lo = lo; start = 1;
    @(negedge clk);
    start = 0;
    if (n == 0) begin
      chk("R9 done not yet", {31'h0, done}, 32'h0);
      @(negedge clk);
      chk("R9 done on second cycle", {31'h0, done}, 32'h1);
    end else begin
      chk("R1 busy after start", {31'h0, busy}, 32'h1);
      if (poke) begin
        repeat (3) @(negedge clk);
        start = 1; in_count = 7; in_ptr_a = 32'h40; in_acc_lo = 32'h1234;
        size_sel = 2'd0;
        @(negedge clk);
        start = 0;
      end
      while (!done) @(negedge clk);
    end
    chk("R6 count zero", out_count, 32'h0);
    chk("R3 ptr a final", out_ptr_a, a + n * nb);
    chk("R3 ptr b final", out_ptr_b, b + n * nb);
    chk(n == 0 ? "R9 acc lo kept" : "R5 acc lo", out_acc_lo, acc[31:0]);
    chk(n == 0 ? "R9 acc mid kept" : "R5 acc mid", out_acc_mid, acc[63:32]);
    chk("R7 acc hi extended", out_acc_hi, hx);
    chk("R8 flag s", {31'h0, flag_s}, {31'h0, hx[31]});
    chk("R8 flag o", {31'h0, flag_o},
        {31'h0, (hx != 32'h0) && (hx != 32'hFFFF_FFFF)});
    chk("R2 all reads issued", addr_q.size(), 0);
    @(negedge clk);
    chk("R11 done single pulse", {31'h0, done}, 32'h0);
    if (poke) chk("R10 idle after run", {31'h0, busy}, 32'h0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset busy", {31'h0, busy}, 32'h0);
    chk("R1 reset done", {31'h0, done}, 32'h0);
    chk("R1 reset req", {31'h0, mem_req}, 32'h0);
    chk("R1 reset flags", {30'h0, flag_s, flag_o}, 32'h0);
    rst_n = 1;
    run_case(0, 32'h100, 32'h200, 5, 32'h0, 32'h0, 32'h0, 0, 0);     // R4 byte
    run_case(1, 32'h302, 32'h500, 4, 32'h0, 32'h0, 32'h0, 2, 0);     // R4 half
    run_case(2, 32'h800, 32'h900, 3, 32'h0, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 1, 0); // R5 carry
    run_case(3, 32'hA00, 32'hB04, 2, 32'h0001_2345, 32'h0, 32'h0, 0, 0); // R8 overflow
    run_case(0, 32'h1, 32'h0, 0, 32'h0000_8000, 32'h5, 32'h6, 0, 0);   // R9 negative
    run_case(1, 32'h2, 32'h4, 0, 32'h1234_0001, 32'h7, 32'h8, 0, 0);   // R9 positive
    run_case(2, 32'hC00, 32'hD00, 4, 32'hFFFF_FFFF, 32'hFFFF_FFFF, 32'h0, 3, 1); // R10
    run_case(0, 32'h77, 32'h1F3, 9, 32'h0, 32'h0, 32'h0, 1, 0);       // R4 byte
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      miscompares++;
      $display("FAIL watchdog expired actual=%0d expected<150000", cycles);
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end
endmodule